// File: doc/BRIEF.md
# Bit-Indexed Sequential Bit Buffer

This block is a 16-bit scratch store for bit-level processing. It is split into four 4-bit nibble registers that sit at four consecutive data addresses, starting at `BASE_ADDR` (FC0h by default). The same storage can be reached in four ways:

- as a single bit named directly by address and bit number;
- as a whole nibble;
- as an aligned byte;
- as a single bit chosen by a 4-bit index register.

The block holds the index register itself. A program loop can load it once and then step it up or down by one. Each step moves the selected bit to the next or previous position, so the loop walks through a long bit string one bit at a time.

The access port works like a memory port. It has a strobe, a write enable, a 2-bit size/mode select, an address, a bit number and write data. Reads come straight from the register contents with no clock delay. Writes take effect on the rising clock edge and change only the bits that the access size selects. The indirect-bit mode ignores the address, so it reaches the buffer whatever the bank configuration of the surrounding processor is. A wrap flag pulses when the index rolls over in either direction. An error flag pulses when a byte access is not aligned.

Top module: `bitseq_buf`

## Requirements
- R1: A synchronous reset clears all 16 buffer bits, sets the index to 0 and drives `wrap` and `err` low.
- R2: With `acc_size`=11 (indirect bit), index value n selects overall bit n: nibble n/4, bit n%4. A read returns that bit on `rdata[0]` with the other bits 0. A write stores `wdata[0]` into that bit only. `acc_addr` has no effect in this mode.
- R3: `idx_ld` loads `idx_ld_val` and takes priority over stepping. `idx_inc` alone adds 1, `idx_dec` alone subtracts 1, and both together leave the index unchanged.
- R4: Incrementing from 15 gives 0 and decrementing from 0 gives 15. `wrap` is high for exactly the one cycle after the edge on which such a wrap happened.
- R5: With `acc_size`=00 (direct bit), address `BASE_ADDR`+k with `acc_bit`=b selects overall bit 4k+b. It is read on `rdata[0]` and written from `wdata[0]`.
- R6: With `acc_size`=01 (nibble), address `BASE_ADDR`+k reads nibble k on `rdata[3:0]` with `rdata[7:4]`=0. A write replaces only nibble k, taking its value from `wdata[3:0]`.
- R7: With `acc_size`=10 (byte), address `BASE_ADDR` maps the lower byte: nibble 0 on bits [3:0] and nibble 1 on bits [7:4]. Address `BASE_ADDR`+2 maps the upper byte: nibble 2 on [3:0] and nibble 3 on [7:4].
- R8: A byte access at `BASE_ADDR`+1 or `BASE_ADDR`+3 changes no bit and reads 0. It drives `err` high for exactly the following cycle.
- R9: A direct-bit, nibble or byte access whose address is outside the four buffer addresses changes no bit and reads 0.
- R10: Nothing is written unless both `acc_en` and `acc_we` are high. During a write cycle, `rdata` still shows the old contents until the clock edge. `rdata` is 0 while `acc_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | Write enable for the access |
| acc_size | input | 2 | 00 direct bit, 01 nibble, 10 byte, 11 indirect bit |
| acc_addr | input | 12 | Data address of the access |
| acc_bit | input | 2 | Bit number for a direct-bit access |
| wdata | input | 8 | Write data, right-aligned |
| rdata | output | 8 | Combinational read data, right-aligned |
| idx_ld | input | 1 | Load the index register |
| idx_ld_val | input | 4 | Value to load into the index |
| idx_inc | input | 1 | Step the index up |
| idx_dec | input | 1 | Step the index down |
| idx_q | output | 4 | Current index value |
| wrap | output | 1 | Pulse after an index rollover |
| err | output | 1 | Pulse after a misaligned byte access |

## Verification
The bench builds the block with its default parameters: four nibbles of four bits, a 12-bit address and the base at FC0h. With these values, a walk of sixteen steps visits every index value and crosses both rollover points. The same values place both illegal byte positions and the addresses just below and just above the buffer within a few directed accesses. A shadow copy of the 16 bits, kept by the bench, gives the expected value of every read.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

    typedef enum logic [1:0] {
        ACC_BIT  = 2'b00,
        ACC_NIB  = 2'b01,
        ACC_BYTE = 2'b10,
        ACC_IND  = 2'b11
    } acc_size_e;

endpackage

// File: rtl/bsb_index.sv
module bsb_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [IDX_W-1:0] ld_val,
    input  logic             inc,
    input  logic             dec,
    output logic [IDX_W-1:0] idx_q,
    output logic             wrap_q
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             wrap;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (ld) begin
            st_d.idx = ld_val;
        end else if (inc && !dec) begin
            st_d.idx  = st_q.idx + IDX_ONE;
            st_d.wrap = (st_q.idx == IDX_MAX);
        end else if (dec && !inc) begin
            st_d.idx  = st_q.idx - IDX_ONE;
            st_d.wrap = (st_q.idx == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx_q  = st_q.idx;
    assign wrap_q = st_q.wrap;

    assert_inc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !ld) |=> (idx_q == $past(idx_q) + IDX_ONE));

    assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !ld) |=> (idx_q == $past(idx_q) - IDX_ONE));

    assert_both_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && dec && !ld) |=> $stable(idx_q));

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        ld |=> (idx_q == $past(ld_val)) && !wrap_q);

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !ld && idx_q == IDX_MAX) |=> (wrap_q && idx_q == '0));

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !ld && idx_q == '0) |=> (wrap_q && idx_q == IDX_MAX));

    assert_idle_nowrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!inc && !dec) |=> !wrap_q);

endmodule

// File: rtl/bsb_decode.sv
module bsb_decode
    import bsb_pkg::*;
#(
    parameter int                NUM_NIB   = 4,
    parameter int                NIB_W     = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hFC0,
    localparam int               TOT_W     = NUM_NIB * NIB_W,
    localparam int               DATA_W    = 2 * NIB_W,
    localparam int               IDX_W     = $clog2(TOT_W),
    localparam int               NSEL_W    = $clog2(NUM_NIB),
    localparam int               BSEL_W    = $clog2(NIB_W)
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  acc_size_e         acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BSEL_W-1:0] acc_bit,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TOT_W-1:0]  store,
    output logic [TOT_W-1:0]  wmask,
    output logic [TOT_W-1:0]  wval,
    output logic [DATA_W-1:0] rdata,
    output logic              misalign
);

    logic [NIB_W-1:0]  nib [NUM_NIB];
    logic              hit;
    logic [NSEL_W-1:0] nsel;
    logic [NSEL_W-1:0] nsel_hi;
    logic              wr;

    for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib_view
        assign nib[g] = store[g*NIB_W +: NIB_W];
    end

    assign hit     = (acc_addr[ADDR_W-1:NSEL_W] == BASE_ADDR[ADDR_W-1:NSEL_W]);
    assign nsel    = acc_addr[NSEL_W-1:0];
    assign nsel_hi = nsel | NSEL_W'(1);
    assign wr      = acc_en && acc_we;

    always_comb begin
        logic [IDX_W-1:0] pos;
        wmask    = '0;
        wval     = '0;
        rdata    = '0;
        misalign = 1'b0;
        pos      = '0;
        if (acc_en) begin
            unique case (acc_size)
                ACC_IND: begin
                    pos       = idx;
                    rdata[0]  = store[pos];
                    wmask[pos] = wr;
                    wval[pos]  = wdata[0];
                end
                ACC_BIT: begin
                    if (hit) begin
                        pos        = {nsel, acc_bit};
                        rdata[0]   = store[pos];
                        wmask[pos] = wr;
                        wval[pos]  = wdata[0];
                    end
                end
                ACC_NIB: begin
                    if (hit) begin
                        rdata[NIB_W-1:0] = nib[nsel];
                        for (int j = 0; j < NIB_W; j++) begin
                            pos        = {nsel, BSEL_W'(j)};
                            wmask[pos] = wr;
                            wval[pos]  = wdata[j];
                        end
                    end
                end
                ACC_BYTE: begin
                    if (hit && nsel[0]) begin
                        misalign = 1'b1;
                    end else if (hit) begin
                        rdata = {nib[nsel_hi], nib[nsel]};
                        for (int j = 0; j < DATA_W; j++) begin
                            pos        = {nsel, {BSEL_W{1'b0}}} + IDX_W'(j);
                            wmask[pos] = wr;
                            wval[pos]  = wdata[j];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        assert_mask_onehot_bit_R5: assert ((acc_size != ACC_BIT && acc_size != ACC_IND)
                                           || $countones(wmask) <= 1);
        assert_misalign_nomask_R8: assert (!misalign || wmask == '0);
    end

endmodule

// File: rtl/bitseq_buf.sv
module bitseq_buf
    import bsb_pkg::*;
#(
    parameter int                NUM_NIB   = 4,
    parameter int                NIB_W     = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hFC0,
    localparam int               TOT_W     = NUM_NIB * NIB_W,
    localparam int               DATA_W    = 2 * NIB_W,
    localparam int               IDX_W     = $clog2(TOT_W),
    localparam int               BSEL_W    = $clog2(NIB_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BSEL_W-1:0] acc_bit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              idx_ld,
    input  logic [IDX_W-1:0]  idx_ld_val,
    input  logic              idx_inc,
    input  logic              idx_dec,
    output logic [IDX_W-1:0]  idx_q,
    output logic              wrap,
    output logic              err
);

    typedef struct packed {
        logic [TOT_W-1:0] bits;
        logic             err;
    } buf_st_t;

    buf_st_t          st_d, st_q;
    logic [TOT_W-1:0] wmask;
    logic [TOT_W-1:0] wval;
    logic             misalign;

    bsb_index #(.IDX_W(IDX_W)) u_index (
        .clk    (clk),
        .rst    (rst),
        .ld     (idx_ld),
        .ld_val (idx_ld_val),
        .inc    (idx_inc),
        .dec    (idx_dec),
        .idx_q  (idx_q),
        .wrap_q (wrap)
    );

    bsb_decode #(
        .NUM_NIB   (NUM_NIB),
        .NIB_W     (NIB_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_size (acc_size_e'(acc_size)),
        .acc_addr (acc_addr),
        .acc_bit  (acc_bit),
        .wdata    (wdata),
        .idx      (idx_q),
        .store    (st_q.bits),
        .wmask    (wmask),
        .wval     (wval),
        .rdata    (rdata),
        .misalign (misalign)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~wmask) | (wval & wmask);
        st_d.err  = misalign;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign err = st_q.err;

    assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && acc_we) |=> $stable(st_q.bits));

    assert_misalign_err_R8: assert property (@(posedge clk) disable iff (rst)
        misalign |=> (err && $stable(st_q.bits)));

    assert_err_only_after_misalign_R8: assert property (@(posedge clk) disable iff (rst)
        !misalign |=> !err);

    assert_ind_single_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_we && acc_size == 2'b11)
            |=> ($countones(st_q.bits ^ $past(st_q.bits)) <= 1));

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (rdata == '0));

endmodule

// File: tb/bitseq_buf_tb.sv
module bitseq_buf_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_en, acc_we;
    logic [1:0]  acc_size;
    logic [11:0] acc_addr;
    logic [1:0]  acc_bit;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        idx_ld, idx_inc, idx_dec;
    logic [3:0]  idx_ld_val;
    logic [3:0]  idx_q;
    logic        wrap, err;

    localparam logic [1:0] S_BIT = 2'b00, S_NIB = 2'b01, S_BYTE = 2'b10, S_IND = 2'b11;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [15:0] mdl;

    always #2.5 clk = ~clk;

    bitseq_buf u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_bit(acc_bit), .wdata(wdata), .rdata(rdata),
        .idx_ld(idx_ld), .idx_ld_val(idx_ld_val), .idx_inc(idx_inc), .idx_dec(idx_dec),
        .idx_q(idx_q), .wrap(wrap), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_en = 0; acc_we = 0; acc_size = S_BIT; acc_addr = '0; acc_bit = '0; wdata = '0;
        idx_ld = 0; idx_ld_val = '0; idx_inc = 0; idx_dec = 0;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [11:0] a, input logic [1:0] b,
                      input logic [7:0] d);
        @(negedge clk);
        acc_en = 1; acc_we = 1; acc_size = sz; acc_addr = a; acc_bit = b; wdata = d;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic rd(input logic [1:0] sz, input logic [11:0] a, input logic [1:0] b,
                      output logic [7:0] d);
        @(negedge clk);
        acc_en = 1; acc_we = 0; acc_size = sz; acc_addr = a; acc_bit = b;
        #1 d = rdata;
        idle();
    endtask

    task automatic idx_op(input logic ld, input logic [3:0] v, input logic inc, input logic dec);
        @(negedge clk);
        idx_ld = ld; idx_ld_val = v; idx_inc = inc; idx_dec = dec;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(S_NIB, 12'hFC0 + 12'(k), 2'd0, d);
            check(req, int'(d), int'({4'h0, mdl[k*4 +: 4]}));
        end
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        mdl = '0;
        check("R1 idx", int'(idx_q), 0);
        check("R1 wrap", int'(wrap), 0);
        check("R1 err", int'(err), 0);
        check_all("R1 buffer");
    endtask

    task automatic t_nibble();
        logic [7:0] d;
        wr(S_NIB, 12'hFC0, 2'd0, 8'hFA); mdl[3:0]   = 4'hA;
        wr(S_NIB, 12'hFC1, 2'd0, 8'h35); mdl[7:4]   = 4'h5;
        wr(S_NIB, 12'hFC2, 2'd0, 8'h0C); mdl[11:8]  = 4'hC;
        wr(S_NIB, 12'hFC3, 2'd0, 8'h73); mdl[15:12] = 4'h3;
        check_all("R6 nibble");
        rd(S_BYTE, 12'hFC0, 2'd0, d);
        check("R7 lower byte", int'(d), int'(mdl[7:0]));
        rd(S_BYTE, 12'hFC2, 2'd0, d);
        check("R7 upper byte", int'(d), int'(mdl[15:8]));
    endtask

    task automatic t_direct_bit();
        logic [7:0] d;
        wr(S_BIT, 12'hFC2, 2'd1, 8'hFF); mdl[9]  = 1'b1;
        wr(S_BIT, 12'hFC3, 2'd3, 8'h00); mdl[15] = 1'b0;
        wr(S_BIT, 12'hFC1, 2'd2, 8'h01); mdl[6]  = 1'b1;
        check_all("R5 direct write");
        for (int n = 0; n < 16; n++) begin
            rd(S_BIT, 12'hFC0 + 12'(n / 4), 2'(n % 4), d);
            check("R5 direct read", int'(d), int'(mdl[n]));
        end
    endtask

    task automatic t_indirect_walk();
        logic [7:0] d;
        logic [15:0] pat = 16'h6D29;
        idx_op(1, 4'd0, 0, 0);
        check("R3 load", int'(idx_q), 0);
        for (int n = 0; n < 16; n++) begin
            wr(S_IND, 12'h123, 2'd3, {7'h7F, pat[n]});
            mdl[n] = pat[n];
            rd(S_IND, 12'h000, 2'd0, d);
            check("R2 indirect read", int'(d), int'(pat[n]));
            idx_op(0, 4'd0, 1, 0);
            check("R3 inc", int'(idx_q), (n + 1) % 16);
            check("R4 wrap on inc", int'(wrap), (n == 15) ? 1 : 0);
        end
        check_all("R2 indirect contents");
        idx_op(0, 4'd0, 0, 0);
        check("R4 wrap one cycle", int'(wrap), 0);
    endtask

    task automatic t_dec_and_both();
        idx_op(1, 4'd1, 0, 0);
        idx_op(0, 4'd0, 0, 1);
        check("R3 dec", int'(idx_q), 0);
        check("R4 no wrap 1->0", int'(wrap), 0);
        idx_op(0, 4'd0, 0, 1);
        check("R4 dec wrap idx", int'(idx_q), 15);
        check("R4 dec wrap flag", int'(wrap), 1);
        idx_op(0, 4'd0, 1, 1);
        check("R3 inc+dec hold", int'(idx_q), 15);
        check("R3 inc+dec no wrap", int'(wrap), 0);
        idx_op(1, 4'd7, 1, 0);
        check("R3 load priority", int'(idx_q), 7);
        check("R3 load no wrap", int'(wrap), 0);
    endtask

    task automatic t_byte();
        logic [7:0] d;
        wr(S_BYTE, 12'hFC2, 2'd0, 8'h9E); mdl[15:8] = 8'h9E;
        wr(S_BYTE, 12'hFC0, 2'd0, 8'h41); mdl[7:0]  = 8'h41;
        check_all("R7 byte write");
        rd(S_BYTE, 12'hFC2, 2'd0, d);
        check("R7 upper byte read", int'(d), 16'h9E);
    endtask

    task automatic t_misalign();
        logic [7:0] d;
        wr(S_BYTE, 12'hFC1, 2'd0, 8'hFF);
        check("R8 err after FC1", int'(err), 1);
        idx_op(0, 4'd0, 0, 0);
        check("R8 err one cycle", int'(err), 0);
        wr(S_BYTE, 12'hFC3, 2'd0, 8'h00);
        check("R8 err after FC3", int'(err), 1);
        rd(S_BYTE, 12'hFC3, 2'd0, d);
        check("R8 misaligned read", int'(d), 0);
        check_all("R8 buffer unchanged");
    endtask

    task automatic t_outside();
        logic [7:0] d;
        wr(S_NIB, 12'hFC4, 2'd0, 8'h0F);
        wr(S_NIB, 12'hFBF, 2'd0, 8'h0F);
        wr(S_BIT, 12'h7C0, 2'd0, 8'h01);
        wr(S_BYTE, 12'hEC0, 2'd0, 8'hFF);
        check_all("R9 outside writes");
        rd(S_NIB, 12'hFC4, 2'd0, d);
        check("R9 outside read", int'(d), 0);
        rd(S_BYTE, 12'h0C0, 2'd0, d);
        check("R9 outside byte read", int'(d), 0);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        @(negedge clk);
        acc_en = 1; acc_we = 0; acc_size = S_NIB; acc_addr = 12'hFC1; wdata = 8'h0F;
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        acc_en = 0; acc_we = 1; acc_size = S_BYTE; acc_addr = 12'hFC0; wdata = 8'hFF;
        #1 check("R10 rdata idle", int'(rdata), 0);
        @(posedge clk); #1;
        idle();
        check_all("R10 no write without strobes");
        @(negedge clk);
        acc_en = 1; acc_we = 1; acc_size = S_NIB; acc_addr = 12'hFC3; wdata = 8'h0B;
        #1 check("R10 old data before edge", int'(rdata), int'(mdl[15:12]));
        @(posedge clk); #1;
        idle();
        mdl[15:12] = 4'hB;
        rd(S_NIB, 12'hFC3, 2'd0, d);
        check("R10 new data after edge", int'(d), 11);
    endtask

    initial begin
        #100000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        idle();
        t_reset();
        t_nibble();
        t_direct_bit();
        t_indirect_walk();
        t_dec_and_both();
        t_byte();
        t_misalign();
        t_outside();
        t_enable();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule